// File: doc/BRIEF.md
# Transceiver Reconfiguration Register Streamer

This block is a memory-mapped register slave that lets software change one word of a transceiver channel's internal configuration space at a time. Software stages three values in their own registers: a logical channel number, a word offset and a 16-bit data word. It then writes a control/status register that selects the operating mode and carries a start bit. When the start bit arrives with direct mode selected, the block drives a single write request to the channel configuration fabric on a downstream port. It holds that request until the fabric acknowledges it.

A busy flag in the control/status register stays set for the whole downstream transaction. While it is set, all staging registers and the mode are frozen. Software polls the flag before staging the next record. A configuration record that is several words long is sent by loading the next offset and data word and starting again, once per word.

Top module: `recfg_streamer_regs`

## Requirements
- R1: While rst_ni is low, and after it rises, dn_wr_o is 0, rdata_o is 0, and every register reads back 0.
- R2: Word address 0x38 holds the channel (low CH_W bits), 0x3B the offset (low OFF_W bits) and 0x3C the data word (low DAT_W bits). A read returns the staged value zero-extended to 32 bits on rdata_o in the cycle after read_i.
- R3: Any other address reads as 0. A write to it changes no register.
- R4: Control/status register 0x3A: bits [3:2] hold the mode (00 streaming, 01 direct, 10 and 11 reserved) and read back as written. Bit 8 is the read-only busy flag. Every other bit reads 0.
- R5: A write to 0x3A with bit 0 set and bits [3:2] = 01 while idle raises dn_wr_o and the busy flag in the next cycle. dn_chan_o, dn_offset_o and dn_data_o carry the staged channel, offset and data.
- R6: dn_wr_o and its channel, offset and data stay constant until dn_ack_i is sampled high. dn_wr_o and busy are 0 in the following cycle.
- R7: A start bit with any mode other than 01 starts no downstream write. The mode is still stored.
- R8: While busy, writes to the channel, offset, data and control/status registers are ignored, including a further start bit.
- R9: The start bit reads as 0. One start produces exactly one downstream write, and nothing repeats after the acknowledge.
- R10: Successive records (new offset and data, then a start, once per word) each produce one downstream write with that record's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register word address |
| write_i | input | 1 | Register write request |
| read_i | input | 1 | Register read request |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, valid one cycle after read_i |
| dn_wr_o | output | 1 | Downstream write request, held until acknowledged |
| dn_chan_o | output | CH_W | Downstream logical channel |
| dn_offset_o | output | OFF_W | Downstream word offset |
| dn_data_o | output | DAT_W | Downstream data word |
| dn_ack_i | input | 1 | Downstream acknowledge |

## Verification
The hardest case to reach is register writes that land inside the busy window. The bench holds dn_ack_i low after a start, so the window stays open as long as it needs. During that window it writes new channel, offset and data values, a reserved mode and a second start bit. It then checks that the downstream outputs do not move. After the acknowledge, it reads every register back and watches dn_wr_o for several idle cycles, which shows that no second write was queued.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
  localparam int unsigned BUS_W = 32;

  // word addresses decoded by the register slave
  localparam logic [7:0] ADR_CHAN = 8'h38;
  localparam logic [7:0] ADR_CTRL = 8'h3A;
  localparam logic [7:0] ADR_OFFS = 8'h3B;
  localparam logic [7:0] ADR_DATA = 8'h3C;

  localparam int unsigned CTRL_GO_BIT   = 0;
  localparam int unsigned CTRL_MODE_LSB = 2;
  localparam int unsigned CTRL_BUSY_BIT = 8;

  typedef enum logic [1:0] {
    MODE_STREAM = 2'b00,
    MODE_DIRECT = 2'b01,
    MODE_RSVD2  = 2'b10,
    MODE_RSVD3  = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CHAN,
    SEL_CTRL,
    SEL_OFFS,
    SEL_DATA
  } reg_sel_e;

  typedef enum logic {
    ST_IDLE,
    ST_REQ
  } wr_state_e;
endpackage

// File: rtl/recfg_addr_dec.sv
module recfg_addr_dec
  import recfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    if      (addr_i == ADDR_W'(ADR_CHAN)) sel_o = SEL_CHAN;
    else if (addr_i == ADDR_W'(ADR_CTRL)) sel_o = SEL_CTRL;
    else if (addr_i == ADDR_W'(ADR_OFFS)) sel_o = SEL_OFFS;
    else if (addr_i == ADDR_W'(ADR_DATA)) sel_o = SEL_DATA;
    else                                  sel_o = SEL_NONE;
  end
endmodule

// File: rtl/recfg_stage_regs.sv
module recfg_stage_regs
  import recfg_pkg::*;
#(
  parameter int unsigned CH_W  = 10,
  parameter int unsigned OFF_W = 11,
  parameter int unsigned DAT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  reg_sel_e         sel_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             busy_i,
  output logic [CH_W-1:0]  chan_o,
  output logic [OFF_W-1:0] offs_o,
  output logic [DAT_W-1:0] data_o,
  output mode_e            mode_o,
  output logic             launch_o
);
  localparam int unsigned MAXW_A = (CH_W > OFF_W) ? CH_W : OFF_W;
  localparam int unsigned MAXW   = (MAXW_A > DAT_W) ? MAXW_A : DAT_W;
  localparam logic [BUS_W-1:0] USED_MASK =
      BUS_W'((64'd1 << MAXW) - 64'd1) | BUS_W'(32'h0000_000D);

  logic  upd;
  mode_e mode_wr;
  logic  unused_wbits;

  // all staging is frozen while a downstream write is outstanding
  assign upd      = wr_en_i && !busy_i;
  assign mode_wr  = mode_e'(wdata_i[CTRL_MODE_LSB +: 2]);
  assign launch_o = upd && (sel_i == SEL_CTRL) && wdata_i[CTRL_GO_BIT]
                    && (mode_wr == MODE_DIRECT);
  assign unused_wbits = ^(wdata_i & ~USED_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_o <= '0;
      offs_o <= '0;
      data_o <= '0;
      mode_o <= MODE_STREAM;
    end else if (upd) begin
      unique case (sel_i)
        SEL_CHAN: chan_o <= wdata_i[CH_W-1:0];
        SEL_OFFS: offs_o <= wdata_i[OFF_W-1:0];
        SEL_DATA: data_o <= wdata_i[DAT_W-1:0];
        SEL_CTRL: mode_o <= mode_wr;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/recfg_wr_fsm.sv
module recfg_wr_fsm
  import recfg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic ack_i,
  output logic req_o
);
  wr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (launch_i) state_d = ST_REQ;
      ST_REQ:  if (ack_i)    state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign req_o = (state_q == ST_REQ);
endmodule

// File: rtl/recfg_rd_mux.sv
module recfg_rd_mux
  import recfg_pkg::*;
#(
  parameter int unsigned CH_W  = 10,
  parameter int unsigned OFF_W = 11,
  parameter int unsigned DAT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  reg_sel_e         sel_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [OFF_W-1:0] offs_i,
  input  logic [DAT_W-1:0] data_i,
  input  mode_e            mode_i,
  input  logic             busy_i,
  output logic [BUS_W-1:0] rdata_o
);
  logic [BUS_W-1:0] ctrl_word;
  logic [BUS_W-1:0] rd_d;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_MODE_LSB +: 2] = mode_i;
    ctrl_word[CTRL_BUSY_BIT]      = busy_i;
  end

  always_comb begin
    unique case (sel_i)
      SEL_CHAN: rd_d = BUS_W'(chan_i);
      SEL_CTRL: rd_d = ctrl_word;
      SEL_OFFS: rd_d = BUS_W'(offs_i);
      SEL_DATA: rd_d = BUS_W'(data_i);
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_d;
  end
endmodule

// File: rtl/recfg_streamer_regs.sv
module recfg_streamer_regs
  import recfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CH_W   = 10,
  parameter int unsigned OFF_W  = 11,
  parameter int unsigned DAT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              read_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              dn_wr_o,
  output logic [CH_W-1:0]   dn_chan_o,
  output logic [OFF_W-1:0]  dn_offset_o,
  output logic [DAT_W-1:0]  dn_data_o,
  input  logic              dn_ack_i
);
  reg_sel_e sel;
  mode_e    mode;
  logic     launch;
  logic     busy;

  recfg_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  recfg_stage_regs #(.CH_W(CH_W), .OFF_W(OFF_W), .DAT_W(DAT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (write_i),
    .sel_i    (sel),
    .wdata_i  (wdata_i),
    .busy_i   (busy),
    .chan_o   (dn_chan_o),
    .offs_o   (dn_offset_o),
    .data_o   (dn_data_o),
    .mode_o   (mode),
    .launch_o (launch)
  );

  recfg_wr_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .ack_i    (dn_ack_i),
    .req_o    (busy)
  );

  recfg_rd_mux #(.CH_W(CH_W), .OFF_W(OFF_W), .DAT_W(DAT_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (read_i),
    .sel_i   (sel),
    .chan_i  (dn_chan_o),
    .offs_i  (dn_offset_o),
    .data_i  (dn_data_o),
    .mode_i  (mode),
    .busy_i  (busy),
    .rdata_o (rdata_o)
  );

  assign dn_wr_o = busy;
endmodule

// File: rtl/recfg_streamer_regs_chk.sv
module recfg_streamer_regs_chk
  import recfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CH_W   = 10,
  parameter int unsigned OFF_W  = 11,
  parameter int unsigned DAT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              write_i,
  input logic              read_i,
  input logic              go_i,
  input logic [1:0]        mode_i,
  input logic [31:0]       rdata_o,
  input logic              dn_wr_o,
  input logic [CH_W-1:0]   dn_chan_o,
  input logic [OFF_W-1:0]  dn_offset_o,
  input logic [DAT_W-1:0]  dn_data_o,
  input logic              dn_ack_i
);
  logic is_ctrl, mapped, start_direct, start_other;

  assign is_ctrl = (addr_i == ADDR_W'(ADR_CTRL));
  assign mapped  = is_ctrl || (addr_i == ADDR_W'(ADR_CHAN)) ||
                   (addr_i == ADDR_W'(ADR_OFFS)) || (addr_i == ADDR_W'(ADR_DATA));
  assign start_direct = write_i && is_ctrl && go_i && (mode_i == 2'b01);
  assign start_other  = write_i && is_ctrl && go_i && (mode_i != 2'b01);

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R1: assert (!dn_wr_o && rdata_o == 32'd0);
  end

  assert_unmapped_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_i && !mapped |=> rdata_o == 32'd0);

  assert_busy_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_i && is_ctrl |=> rdata_o[8] == $past(dn_wr_o));

  assert_launch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_direct && !dn_wr_o |=> dn_wr_o);

  assert_launch_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dn_wr_o) |-> $past(start_direct));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_wr_o && !dn_ack_i |=> dn_wr_o);

  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_wr_o && dn_ack_i |=> !dn_wr_o);

  assert_no_other_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_other && !dn_wr_o |=> !dn_wr_o);

  assert_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_wr_o |=> $stable(dn_chan_o) && $stable(dn_offset_o) && $stable(dn_data_o));

  assert_go_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_i && is_ctrl |=> !rdata_o[0]);
endmodule

bind recfg_streamer_regs recfg_streamer_regs_chk #(
  .ADDR_W(ADDR_W), .CH_W(CH_W), .OFF_W(OFF_W), .DAT_W(DAT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .write_i     (write_i),
  .read_i      (read_i),
  .go_i        (wdata_i[0]),
  .mode_i      (wdata_i[3:2]),
  .rdata_o     (rdata_o),
  .dn_wr_o     (dn_wr_o),
  .dn_chan_o   (dn_chan_o),
  .dn_offset_o (dn_offset_o),
  .dn_data_o   (dn_data_o),
  .dn_ack_i    (dn_ack_i)
);

// File: tb/recfg_streamer_regs_test.sv
module recfg_streamer_regs_test;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned CH_W   = 10;
  localparam int unsigned OFF_W  = 11;
  localparam int unsigned DAT_W  = 16;

  localparam logic [7:0] A_CHAN = 8'h38;
  localparam logic [7:0] A_CTRL = 8'h3A;
  localparam logic [7:0] A_OFFS = 8'h3B;
  localparam logic [7:0] A_DATA = 8'h3C;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              write_i = 1'b0;
  logic              read_i = 1'b0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic              dn_wr_o;
  logic [CH_W-1:0]   dn_chan_o;
  logic [OFF_W-1:0]  dn_offset_o;
  logic [DAT_W-1:0]  dn_data_o;
  logic              dn_ack_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  recfg_streamer_regs #(.ADDR_W(ADDR_W), .CH_W(CH_W), .OFF_W(OFF_W), .DAT_W(DAT_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .write_i(write_i), .read_i(read_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .dn_wr_o(dn_wr_o), .dn_chan_o(dn_chan_o),
    .dn_offset_o(dn_offset_o), .dn_data_o(dn_data_o), .dn_ack_i(dn_ack_i)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; write_i = 1'b1;
    @(negedge clk_i);
    write_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    addr_i = a; read_i = 1'b1;
    @(negedge clk_i);
    read_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic give_ack();
    dn_ack_i = 1'b1;
    @(negedge clk_i);
    dn_ack_i = 1'b0;
  endtask

  task automatic stage(input logic [31:0] ch, input logic [31:0] off, input logic [31:0] dat);
    bus_write(A_CHAN, ch);
    bus_write(A_OFFS, off);
    bus_write(A_DATA, dat);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check(dn_wr_o == 1'b0, "R1 dn_wr_o in reset", 32'(dn_wr_o), 0);
    check(rdata_o == 0, "R1 rdata_o in reset", rdata_o, 0);
    @(negedge clk_i); rst_ni = 1'b1; @(negedge clk_i);
    bus_read(A_CHAN, r); check(r == 0, "R1 chan after reset", r, 0);
    bus_read(A_CTRL, r); check(r == 0, "R1 ctrl after reset", r, 0);
    bus_read(A_OFFS, r); check(r == 0, "R1 offset after reset", r, 0);
    bus_read(A_DATA, r); check(r == 0, "R1 data after reset", r, 0);
  endtask

  task automatic t_readback();
    logic [31:0] r;
    stage(32'hFFFF_F2A5, 32'hFFFF_FFFF, 32'hABCD_1234);
    bus_read(A_CHAN, r); check(r == 32'h0000_02A5, "R2 chan truncated", r, 32'h2A5);
    bus_read(A_OFFS, r); check(r == 32'h0000_07FF, "R2 offset truncated", r, 32'h7FF);
    bus_read(A_DATA, r); check(r == 32'h0000_1234, "R2 data truncated", r, 32'h1234);
    bus_write(A_CTRL, 32'hFFFF_FEFE);  // mode 11, start bit clear
    bus_read(A_CTRL, r); check(r == 32'h0000_000C, "R4 ctrl layout", r, 32'hC);
    check(dn_wr_o == 1'b0, "R7 no start without go", 32'(dn_wr_o), 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] r;
    bus_write(8'h39, 32'hFFFF_FFFF);
    bus_write(8'h3D, 32'h5555_5555);
    bus_read(8'h39, r); check(r == 0, "R3 read 0x39", r, 0);
    bus_read(8'h3D, r); check(r == 0, "R3 read 0x3D", r, 0);
    bus_read(8'h00, r); check(r == 0, "R3 read 0x00", r, 0);
    bus_read(A_CHAN, r); check(r == 32'h2A5, "R3 chan untouched", r, 32'h2A5);
    bus_read(A_DATA, r); check(r == 32'h1234, "R3 data untouched", r, 32'h1234);
  endtask

  task automatic t_direct_write();
    logic [31:0] r;
    stage(32'h3, 32'h010, 32'hBEEF);
    bus_write(A_CTRL, 32'h5);
    check(dn_wr_o == 1'b1, "R5 strobe raised", 32'(dn_wr_o), 1);
    check(dn_chan_o == 10'h3, "R5 channel", 32'(dn_chan_o), 3);
    check(dn_offset_o == 11'h010, "R5 offset", 32'(dn_offset_o), 32'h10);
    check(dn_data_o == 16'hBEEF, "R5 data", 32'(dn_data_o), 32'hBEEF);
    bus_read(A_CTRL, r);
    check(r == 32'h0000_0104, "R9 go reads 0, busy set, mode direct", r, 32'h104);
    for (int i = 0; i < 5; i++) @(negedge clk_i);
    check(dn_wr_o == 1'b1 && dn_data_o == 16'hBEEF, "R6 held without ack",
          {15'd0, dn_wr_o, dn_data_o}, 32'h1BEEF);
    give_ack();
    check(dn_wr_o == 1'b0, "R6 strobe drops after ack", 32'(dn_wr_o), 0);
    bus_read(A_CTRL, r); check(r == 32'h4, "R6 busy clear", r, 32'h4);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      check(dn_wr_o == 1'b0, "R9 no repeat", 32'(dn_wr_o), 0);
    end
  endtask

  task automatic t_busy_ignore();
    logic [31:0] r;
    stage(32'h1, 32'h022, 32'h0F0F);
    bus_write(A_CTRL, 32'h5);
    check(dn_wr_o == 1'b1, "R8 write started", 32'(dn_wr_o), 1);
    bus_write(A_CHAN, 32'h3FF);
    bus_write(A_OFFS, 32'h7AA);
    bus_write(A_DATA, 32'hCAFE);
    bus_write(A_CTRL, 32'h9);
    bus_write(A_CTRL, 32'h5);
    check(dn_chan_o == 10'h1 && dn_offset_o == 11'h022 && dn_data_o == 16'h0F0F,
          "R8 outputs frozen while busy", 32'(dn_data_o), 32'h0F0F);
    give_ack();
    check(dn_wr_o == 1'b0, "R8 single write", 32'(dn_wr_o), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      check(dn_wr_o == 1'b0, "R8 ignored go not queued", 32'(dn_wr_o), 0);
    end
    bus_read(A_CHAN, r); check(r == 32'h1, "R8 chan kept", r, 1);
    bus_read(A_OFFS, r); check(r == 32'h22, "R8 offset kept", r, 32'h22);
    bus_read(A_DATA, r); check(r == 32'h0F0F, "R8 data kept", r, 32'h0F0F);
    bus_read(A_CTRL, r); check(r == 32'h4, "R8 mode kept", r, 32'h4);
  endtask

  task automatic t_other_mode();
    logic [31:0] r;
    bus_write(A_CTRL, 32'h9);
    for (int i = 0; i < 3; i++) begin
      check(dn_wr_o == 1'b0, "R7 reserved mode no write", 32'(dn_wr_o), 0);
      @(negedge clk_i);
    end
    bus_read(A_CTRL, r); check(r == 32'h8, "R7 mode stored", r, 32'h8);
    bus_write(A_CTRL, 32'h1);
    check(dn_wr_o == 1'b0, "R7 streaming mode no write", 32'(dn_wr_o), 0);
    bus_read(A_CTRL, r); check(r == 32'h0, "R7 streaming stored", r, 0);
  endtask

  task automatic t_records();
    logic [15:0] rec [3];
    rec[0] = 16'h2820; rec[1] = 16'h23B0; rec[2] = 16'h81D4;
    bus_write(A_CHAN, 32'h0);
    for (int k = 0; k < 3; k++) begin
      bus_write(A_OFFS, 32'(k));
      bus_write(A_DATA, 32'(rec[k]));
      bus_write(A_CTRL, 32'h5);
      check(dn_wr_o == 1'b1 && dn_offset_o == 11'(k) && dn_data_o == rec[k],
            "R10 record write", {5'd0, dn_offset_o, dn_data_o}, {5'd0, 11'(k), rec[k]});
      @(negedge clk_i);
      give_ack();
      check(dn_wr_o == 1'b0, "R10 record done", 32'(dn_wr_o), 0);
    end
  endtask

  initial begin
    t_reset();
    t_readback();
    t_unmapped();
    t_direct_write();
    t_busy_ignore();
    t_other_mode();
    t_records();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule